// File: doc/BRIEF.md
# Interrupt and DMA Response Controller

This block sits beside a simple sequential processor and decides who gets attention next: a peripheral asking for the bus to move data directly, or one of several prioritized interrupt sources asking for a service routine. The processor reports, cycle by cycle, when a bus access cycle ends and when an instruction ends. A bus request is granted at the first access-cycle end, even in the middle of an instruction. A direct transfer does not touch the running program, so it causes no context save. Interrupts are considered only at instruction ends, and never while a bus request is pending or granted.

When an interrupt is accepted, the block runs a fixed three-step hardware response. It first clears the interrupt enable. It then pushes the return address and the previous priority level onto an internal nesting stack. Finally it issues a program-counter load to the entry address of the chosen source and raises a one-hot acknowledge. A source of higher urgency (lower index) may interrupt a running routine. A return pulse pops the stack, reloads the saved address and restores the earlier level.

Top module: `irq_dma_ctrl`

## Requirements
- R1: After reset, `dma_grant` is 0, `int_en` is 1, `pc_load` is 0 and `irq_ack` is all zeros, and no level is active.
- R2: `dma_grant` becomes 1 in the cycle after an edge where `dma_req` and `bus_cyc_end` are both 1, whatever the value of `instr_end`. It stays 0 while `bus_cyc_end` is 0.
- R3: Once set, `dma_grant` stays 1 while `dma_req` is 1, and is 0 one cycle after an edge where `dma_req` is 0.
- R4: No interrupt is accepted at an edge where `dma_req` or `dma_grant` is 1.
- R5: An interrupt is accepted only at an edge where `instr_end` is 1. Only sources with an index strictly below the active level are eligible; with no level active, all eight are eligible.
- R6: Among eligible pending sources, the lowest index (index 0 most urgent) is chosen.
- R7: The response runs in this order: `int_en` is 0 one cycle after the accepting edge, the context push happens on the next edge, and two cycles after the accepting edge `pc_load` pulses for one cycle with `int_en` back at 1.
- R8: With the load, `pc_value` equals `VEC_BASE + 4*source` (default base 16'h0100) and `irq_ack` has exactly bit `source` set. The accepted source becomes the active level.
- R9: A one-cycle `ret_pulse` in idle with a non-empty stack gives `pc_load` = 1 the next cycle, with `pc_value` equal to the most recently saved `cur_pc`. It also restores the previous active level, in last-in first-out order.
- R10: The stack holds four entries. With four levels nested, no further interrupt is accepted. A `ret_pulse` with an empty stack produces no `pc_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 8 | Level-sensitive interrupt requests, bit 0 most urgent |
| dma_req | input | 1 | Direct transfer bus request |
| bus_cyc_end | input | 1 | Processor strobe: current bus access cycle ends |
| instr_end | input | 1 | Processor strobe: current instruction ends |
| ret_pulse | input | 1 | Return-from-service pulse |
| cur_pc | input | 16 | Address to resume at, valid with `instr_end` |
| dma_grant | output | 1 | Bus handed to the transfer engine |
| int_en | output | 1 | Interrupt enable flag, cleared during the response |
| pc_load | output | 1 | One-cycle program-counter load strobe |
| pc_value | output | 16 | Address to load with `pc_load` |
| irq_ack | output | 8 | One-hot acknowledge of the accepted source |

## Verification
The assertions take for granted that the processor never raises `instr_end` while the bus is handed away. They also assume `ret_pulse` lasts one cycle and arrives only while the block is idle. The stimulus drives strobes as single-cycle pulses at the falling clock edge. It waits out each three-cycle response before the next event, and raises interrupt strobes only when `dma_req` is low, except in the cases built to show that a bus request blocks acceptance.

// File: rtl/irq_dma_pkg.sv
package irq_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MASK = 2'd1,
    ST_PUSH = 2'd2
  } resp_state_t;
endpackage

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int NSRC = 8,
  localparam int LW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] req,
  input  logic [LW:0]     limit,
  output logic            hit,
  output logic [LW-1:0]   idx
);
  logic [NSRC-1:0] elig;

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_elig
      assign elig[g] = req[g] && (g < int'(limit));
    end
  endgenerate

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        hit = 1'b1;
        idx = LW'(i);
      end
    end
  end
endmodule

// File: rtl/ctx_stack.sv
module ctx_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 20,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (push && !full) mem[cnt[CW-1:0] < CW'(DEPTH) ? cnt : '0] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (push && !full) cnt <= cnt + 1'b1;
    else if (pop && !empty) cnt <= cnt - 1'b1;
  end

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign top   = empty ? '0 : mem[cnt - 1'b1];
endmodule

// File: rtl/dma_arb.sv
module dma_arb (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic cyc_end,
  output logic grant
);
  always_ff @(posedge clk) begin
    if (rst) grant <= 1'b0;
    else if (!req) grant <= 1'b0;
    else if (cyc_end) grant <= 1'b1;
  end
endmodule

// File: rtl/irq_dma_ctrl.sv
module irq_dma_ctrl
  import irq_dma_pkg::*;
#(
  parameter int          NSRC     = 8,
  parameter int          AW       = 16,
  parameter int          DEPTH    = 4,
  parameter logic [15:0] VEC_BASE = 16'h0100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] irq_req,
  input  logic            dma_req,
  input  logic            bus_cyc_end,
  input  logic            instr_end,
  input  logic            ret_pulse,
  input  logic [AW-1:0]   cur_pc,
  output logic            dma_grant,
  output logic            int_en,
  output logic            pc_load,
  output logic [AW-1:0]   pc_value,
  output logic [NSRC-1:0] irq_ack
);
  localparam int LW = $clog2(NSRC);
  localparam int SW = AW + LW + 1;

  resp_state_t   state;
  logic [LW:0]   lvl_q;
  logic [LW-1:0] src_q;
  logic [AW-1:0] ret_q;
  logic          sel_hit;
  logic [LW-1:0] sel_idx;
  logic          stk_full, stk_empty, stk_push, stk_pop;
  logic [SW-1:0] stk_top;
  logic          accept;
  logic [AW-1:0] entry;

  dma_arb u_dma (
    .clk(clk), .rst(rst), .req(dma_req), .cyc_end(bus_cyc_end), .grant(dma_grant)
  );

  irq_prio_sel #(.NSRC(NSRC)) u_sel (
    .req(irq_req), .limit(lvl_q), .hit(sel_hit), .idx(sel_idx)
  );

  ctx_stack #(.DEPTH(DEPTH), .W(SW)) u_stk (
    .clk(clk), .rst(rst), .push(stk_push), .pop(stk_pop),
    .din({ret_q, lvl_q}), .top(stk_top), .full(stk_full), .empty(stk_empty)
  );

  assign stk_pop  = (state == ST_IDLE) && ret_pulse && !stk_empty;
  assign stk_push = (state == ST_MASK);
  assign accept   = (state == ST_IDLE) && !stk_pop && instr_end && sel_hit &&
                    !dma_req && !dma_grant && !stk_full;
  assign entry    = AW'(VEC_BASE) + (AW'(src_q) << 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      int_en   <= 1'b1;
      pc_load  <= 1'b0;
      pc_value <= '0;
      irq_ack  <= '0;
      lvl_q    <= (LW+1)'(NSRC);
      src_q    <= '0;
      ret_q    <= '0;
    end else begin
      pc_load <= 1'b0;
      irq_ack <= '0;
      case (state)
        ST_IDLE: begin
          if (stk_pop) begin
            pc_load  <= 1'b1;
            pc_value <= stk_top[SW-1:LW+1];
            lvl_q    <= stk_top[LW:0];
          end else if (accept) begin
            state  <= ST_MASK;
            int_en <= 1'b0;
            src_q  <= sel_idx;
            ret_q  <= cur_pc;
          end
        end
        ST_MASK: state <= ST_PUSH;
        ST_PUSH: begin
          state    <= ST_IDLE;
          pc_load  <= 1'b1;
          pc_value <= entry;
          irq_ack  <= NSRC'(1) << src_q;
          lvl_q    <= {1'b0, src_q};
          int_en   <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_dma_ctrl_chk.sv
module irq_dma_ctrl_chk #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            dma_req,
  input logic            bus_cyc_end,
  input logic            instr_end,
  input logic            dma_grant,
  input logic            int_en,
  input logic            pc_load,
  input logic [NSRC-1:0] irq_ack
);
  assert_grant_at_cycle_end_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_grant) |-> $past(dma_req && bus_cyc_end));

  assert_grant_release_R3: assert property (@(posedge clk) disable iff (rst)
    (dma_grant && !dma_req) |=> !dma_grant);

  assert_dma_blocks_irq_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(int_en) |-> $past(!dma_req && !dma_grant));

  assert_accept_at_instr_end_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(int_en) |-> $past(instr_end));

  assert_response_order_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(int_en) |=> (!pc_load ##1 (pc_load && int_en)));

  assert_ack_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_ack));

  assert_ack_with_load_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_ack != '0) |-> pc_load);
endmodule

bind irq_dma_ctrl irq_dma_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst(rst), .dma_req(dma_req), .bus_cyc_end(bus_cyc_end),
  .instr_end(instr_end), .dma_grant(dma_grant), .int_en(int_en),
  .pc_load(pc_load), .irq_ack(irq_ack)
);

// File: tb/sim_irq_dma_ctrl.sv
module sim_irq_dma_ctrl;
  localparam int CLK_P = 10;
  localparam logic [15:0] BASE = 16'h0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] irq_req = '0;
  logic dma_req = 1'b0, bus_cyc_end = 1'b0, instr_end = 1'b0, ret_pulse = 1'b0;
  logic [15:0] cur_pc = '0;
  logic dma_grant, int_en, pc_load;
  logic [15:0] pc_value;
  logic [7:0] irq_ack;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_dma_ctrl u0 (
    .clk(clk), .rst(rst), .irq_req(irq_req), .dma_req(dma_req),
    .bus_cyc_end(bus_cyc_end), .instr_end(instr_end), .ret_pulse(ret_pulse),
    .cur_pc(cur_pc), .dma_grant(dma_grant), .int_en(int_en), .pc_load(pc_load),
    .pc_value(pc_value), .irq_ack(irq_ack)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  // R5 R7 R8: accept, three-step response, entry address
  task automatic take_irq(input logic [7:0] req, input logic [15:0] pc, input int src,
                          input string tag);
    irq_req = req; cur_pc = pc; instr_end = 1'b1;
    step; instr_end = 1'b0;
    check({tag, " R7 enable cleared"}, int_en, 0);
    check({tag, " R7 no early load"}, pc_load, 0);
    step;
    check({tag, " R7 no load at push"}, pc_load, 0);
    step;
    check({tag, " R7 load"}, pc_load, 1);
    check({tag, " R7 enable back"}, int_en, 1);
    check({tag, " R8 entry"}, pc_value, BASE + 16'(src * 4));
    check({tag, " R8 ack"}, irq_ack, 8'(1) << src);
    irq_req = '0;
    step;
    check({tag, " R7 load one cycle"}, pc_load, 0);
  endtask

  task automatic no_take(input logic [7:0] req, input string tag);
    irq_req = req; instr_end = 1'b1;
    step; instr_end = 1'b0;
    check({tag, " enable kept"}, int_en, 1);
    for (int k = 0; k < 3; k++) begin
      check({tag, " no load"}, pc_load, 0);
      step;
    end
    irq_req = '0;
  endtask

  task automatic do_ret(input logic [15:0] pc, input string tag);
    ret_pulse = 1'b1;
    step; ret_pulse = 1'b0;
    check({tag, " R9 return load"}, pc_load, 1);
    check({tag, " R9 return address"}, pc_value, pc);
    step;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step; step; rst = 1'b0; step;
    check("R1 grant", dma_grant, 0);
    check("R1 enable", int_en, 1);
    check("R1 load", pc_load, 0);
    check("R1 ack", irq_ack, 0);

    // R2 / R3: grant only at cycle end, mid-instruction allowed
    dma_req = 1'b1;
    step; check("R2 no grant without cycle end", dma_grant, 0);
    bus_cyc_end = 1'b1;
    step; bus_cyc_end = 1'b0;
    check("R2 grant mid-instruction", dma_grant, 1);
    step; check("R3 grant held", dma_grant, 1);
    // R4: interrupt blocked while granted
    irq_req = 8'h10; instr_end = 1'b1;
    step; instr_end = 1'b0;
    check("R4 no accept while granted", int_en, 1);
    dma_req = 1'b0;
    step; check("R3 grant drops", dma_grant, 0);
    check("R4 no load", pc_load, 0);
    // R4: pending request without grant still blocks
    dma_req = 1'b1;
    no_take(8'h10, "R4 pending request");
    check("R2 still no grant", dma_grant, 0);
    dma_req = 1'b0; step;

    // R5: no accept without instruction end
    irq_req = 8'h20;
    for (int k = 0; k < 4; k++) begin
      step; check("R5 waits for instr_end", int_en, 1);
    end
    take_irq(8'h20, 16'h1234, 5, "R5 single");
    do_ret(16'h1234, "R9 single");

    // R6 R8 R9: sweep of all request patterns
    for (int m = 1; m < 256; m++) begin
      int lo = 0;
      for (int b = 7; b >= 0; b--) if (m[b]) lo = b;
      take_irq(8'(m), 16'(m * 37), lo, "R6 sweep");
      do_ret(16'(m * 37), "R9 sweep");
    end

    // R5 nesting and R10 depth limit
    take_irq(8'h20, 16'hA000, 5, "R5 nest L5");
    no_take(8'h60, "R5 lower or equal level");
    take_irq(8'h08, 16'hB000, 3, "R5 nest L3");
    take_irq(8'h04, 16'hC000, 2, "R5 nest L2");
    take_irq(8'h02, 16'hD000, 1, "R5 nest L1");
    no_take(8'h01, "R10 stack full");
    do_ret(16'hD000, "R9 pop 1");
    do_ret(16'hC000, "R9 pop 2");
    take_irq(8'h04, 16'hC100, 2, "R9 level restored");
    do_ret(16'hC100, "R9 pop again");
    do_ret(16'hB000, "R9 pop 3");
    do_ret(16'hA000, "R9 pop 4");
    ret_pulse = 1'b1; step; ret_pulse = 1'b0;
    check("R10 empty return ignored", pc_load, 0);
    step;
    take_irq(8'h80, 16'h0042, 7, "R9 all levels open");
    do_ret(16'h0042, "R9 final");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule